// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the command path of a synchronous DRAM model or controller. It holds the programmed mode word and, when a read or write command arrives, produces the column address for each beat of the burst, one beat per clock. The mode word sets the burst length, the order of the beats, the read latency and whether write bursts are cut to a single beat.

The beat order can be sequential or interleaved. In sequential order the low address bits count up and wrap inside an aligned block of the burst length, while the upper bits keep the start value. In interleaved order the beat index is XORed into the low bits. A full-page sequential burst walks through all 512 columns, wraps back to column 0, and runs until a terminate strobe stops it. A new start strobe during a burst drops the old burst and begins the new one on the next beat. A read-valid flag follows each read beat after the programmed latency.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset `burst_act`, `rd_valid` and `mode_err` are 0, and the active settings are burst length 1, sequential order, latency 2 and normal write bursts.
- R2: A load of a legal mode word takes effect for the next accepted command and clears `mode_err`. Field positions: bits 2:0 length code (0,1,2,3 = 1,2,4,8 beats; 7 = full page), bit 3 order (0 sequential, 1 interleaved), bits 6:4 latency code (2 = two clocks, 3 = three clocks), bit 9 single-beat writes; bits 8:7 and 11:10 must be 0.
- R3: A load of a word with a reserved code or a nonzero must-be-zero bit sets `mode_err` to 1 on the next cycle and keeps the previous settings.
- R4: In sequential order with length BL, beat i shows the start column with its low log2(BL) bits replaced by (start + i) mod BL; the upper bits stay fixed.
- R5: In interleaved order with length BL, beat i shows the start column with its low log2(BL) bits XORed with i.
- R6: Length code 7 with sequential order gives a burst that counts up by one per beat through all 512 columns, wraps from 511 to 0 and does not end by itself; code 7 with interleaved order is reserved.
- R7: An accepted start strobe makes `burst_act` 1 from the next cycle for exactly BL cycles, the first of them showing beat 0.
- R8: A terminate strobe while a burst is running clears `burst_act` on the next cycle.
- R9: A start strobe during a running burst abandons it; the next cycle shows beat 0 of the new burst.
- R10: With bit 9 set, a write burst is one beat at the start column, while reads keep the programmed length.
- R11: `rd_valid` is 1 exactly CL cycles after each cycle in which a read beat is shown, and never follows write beats.
- R12: A start strobe in the cycle of a mode load or in the cycle after it is ignored; one in the second cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_op | input | 12 | Mode word |
| cmd_start | input | 1 | Read/write command strobe; also restarts a running burst |
| cmd_col | input | 9 | Start column of the command |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| cmd_term | input | 1 | Burst terminate strobe |
| col_out | output | 9 | Column address of the current beat |
| burst_act | output | 1 | A burst beat is shown this cycle |
| rd_valid | output | 1 | Read beat delayed by the programmed latency |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The bench builds the block with its default widths: a 9-bit column and a latency pipeline three stages deep. These values put a full 512-column page and its wrap from 511 to 0 within a short run. They also let every burst length and both latencies be combined with random start columns in each order. Directed cases cover the load guard window, rejected words, terminate, restart and single-beat writes.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

    localparam int COL_W  = 9;
    localparam int OP_W   = 12;
    localparam int MAX_CL = 3;
    localparam int MRD    = 2;

    typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

    typedef struct packed {
        logic [COL_W-1:0] mask;      // burst length minus one
        order_e           order;
        logic             full;
        logic [1:0]       lat;       // 2 or 3
        logic             wr_single;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mask: '0, order: ORD_SEQ, full: 1'b0,
                                   lat: 2'd2, wr_single: 1'b0};

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        logic ok;
        ok = (op[11:10] == 2'b00) && (op[8:7] == 2'b00);
        ok = ok && (op[6:4] == 3'd2 || op[6:4] == 3'd3);
        ok = ok && (op[2] == 1'b0 || (op[2:0] == 3'd7 && op[3] == 1'b0));
        return ok;
    endfunction

    function automatic cfg_t op_decode(input logic [OP_W-1:0] op);
        cfg_t c;
        c.order     = order_e'(op[3]);
        c.full      = (op[2:0] == 3'd7);
        c.lat       = op[5:4];
        c.wr_single = op[9];
        case (op[1:0])
            2'd0:    c.mask = COL_W'(0);
            2'd1:    c.mask = COL_W'(1);
            2'd2:    c.mask = COL_W'(3);
            default: c.mask = COL_W'(7);
        endcase
        if (c.full) c.mask = '1;
        return c;
    endfunction

    function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] base,
                                                 input logic [COL_W-1:0] idx,
                                                 input logic [COL_W-1:0] mask,
                                                 input order_e ord);
        logic [COL_W-1:0] low;
        low = (ord == ORD_ILV) ? (base ^ idx) : (base + idx);
        return (base & ~mask) | (low & mask);
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_colgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [OP_W-1:0] op,
    output cfg_t            cfg,
    output logic            err,
    output logic            cmd_ok
);
    localparam int GW = $clog2(MRD + 1);

    logic [GW-1:0] guard;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            err   <= 1'b0;
            guard <= '0;
        end else begin
            if (ld) begin
                guard <= GW'(MRD - 1);
                if (op_legal(op)) begin
                    cfg <= op_decode(op);
                    err <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end else if (guard != '0) begin
                guard <= guard - 1'b1;
            end
        end
    end

    assign cmd_ok = !ld && (guard == '0);

    AST_BAD_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ld && !op_legal(op)) |=> (err && $stable(cfg)));  // R3
    AST_LOAD_GUARD: assert property (@(posedge clk) disable iff (rst)
        ld |=> !cmd_ok);  // R12

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic             start,
    input  logic             start_ok,
    input  logic [COL_W-1:0] col_in,
    input  logic             wr,
    input  logic             term,
    output logic [COL_W-1:0] col,
    output logic             active,
    output logic             rd_beat
);
    logic             acc;
    logic             single;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    order_e           ord_q;
    logic             full_q;
    logic             wr_q;

    assign acc    = start && start_ok;
    assign single = wr && cfg.wr_single;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            ord_q  <= ORD_SEQ;
            full_q <= 1'b0;
            wr_q   <= 1'b0;
        end else if (acc) begin
            active <= 1'b1;
            base_q <= col_in;
            idx_q  <= '0;
            mask_q <= single ? '0 : cfg.mask;
            ord_q  <= cfg.order;
            full_q <= cfg.full && !single;
            wr_q   <= wr;
        end else if (active) begin
            if (term || (!full_q && idx_q == mask_q)) begin
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign col     = beat_col(base_q, idx_q, mask_q, ord_q);
    assign rd_beat = active && !wr_q;

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(acc)) |->
            ((col & ~mask_q) == ($past(col) & ~mask_q)));  // R4
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(acc) && full_q) |->
            (col == COL_W'($past(col) + 1'b1)));  // R6
    AST_TERM_STOP: assert property (@(posedge clk) disable iff (rst)
        (active && term && !acc) |=> !active);  // R8
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc && single) |=> (active && col == $past(col_in) && rd_beat == 1'b0));  // R10

endmodule

// File: rtl/sdr_rdvalid_pipe.sv
module sdr_rdvalid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       beat,
    input  logic [1:0] lat,
    output logic       valid
);
    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[DEPTH-2:0], beat};
    end

    assign valid = stage[lat - 2'd1];

    AST_RDV_LAT2: assert property (@(posedge clk) disable iff (rst)
        (valid && lat == 2'd2) |-> $past(beat, 2));  // R11
    AST_RDV_LAT3: assert property (@(posedge clk) disable iff (rst)
        (valid && lat == 2'd3) |-> $past(beat, 3));  // R11

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_ld,
    input  logic [OP_W-1:0]  mode_op,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_wr,
    input  logic             cmd_term,
    output logic [COL_W-1:0] col_out,
    output logic             burst_act,
    output logic             rd_valid,
    output logic             mode_err
);
    cfg_t cfg;
    logic cmd_ok;
    logic rd_beat;

    sdr_mode_reg i_mode (
        .clk    (clk),
        .rst    (rst),
        .ld     (mode_ld),
        .op     (mode_op),
        .cfg    (cfg),
        .err    (mode_err),
        .cmd_ok (cmd_ok)
    );

    sdr_burst_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .start    (cmd_start),
        .start_ok (cmd_ok),
        .col_in   (cmd_col),
        .wr       (cmd_wr),
        .term     (cmd_term),
        .col      (col_out),
        .active   (burst_act),
        .rd_beat  (rd_beat)
    );

    sdr_rdvalid_pipe #(.DEPTH(MAX_CL)) i_rdv (
        .clk   (clk),
        .rst   (rst),
        .beat  (rd_beat),
        .lat   (cfg.lat),
        .valid (rd_valid)
    );

    AST_LOAD_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (mode_ld && !burst_act) |=> !burst_act);  // R12

endmodule

// File: tb/test_sdr_burst_colgen.sv
module test_sdr_burst_colgen;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_ld;
    logic [11:0] mode_op;
    logic       cmd_start;
    logic [8:0] cmd_col;
    logic       cmd_wr;
    logic       cmd_term;
    logic [8:0] col_out;
    logic       burst_act;
    logic       rd_valid;
    logic       mode_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sdr_burst_colgen i_sdr_burst_colgen (
        .clk(clk), .rst(rst), .mode_ld(mode_ld), .mode_op(mode_op),
        .cmd_start(cmd_start), .cmd_col(cmd_col), .cmd_wr(cmd_wr),
        .cmd_term(cmd_term), .col_out(col_out), .burst_act(burst_act),
        .rd_valid(rd_valid), .mode_err(mode_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_op(input int blc, input bit il,
                                          input int clc, input bit wsingle);
        logic [11:0] w = '0;
        w[2:0] = 3'(blc);
        w[3]   = il;
        w[6:4] = 3'(clc);
        w[9]   = wsingle;
        return w;
    endfunction

    function automatic int exp_col(input int sc, input int i, input int bl, input bit il);
        int lowst, blk, r;
        blk   = (sc / bl) * bl;
        lowst = sc % bl;
        if (!il) return blk + ((lowst + i) % bl);
        r = 0;
        for (int b = 0; b < 9; b++)
            if (((lowst >> b) & 1) != ((i >> b) & 1)) r += (1 << b);
        return blk + (r % bl);
    endfunction

    // Load mode word; returns before the first edge where a start is accepted.
    task automatic load_mode(input logic [11:0] w);
        mode_op = w;
        mode_ld = 1'b1;
        @(negedge clk);
        mode_ld = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_burst(input int sc, input bit wr, input int len, input int bl,
                             input bit il, input int cl, input int stop_after,
                             input string req);
        int n;
        n = (stop_after > 0) ? stop_after : len;
        cmd_col   = 9'(sc);
        cmd_wr    = wr;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < n + cl + 1; i++) begin
            check(burst_act == (i < n), req, "burst_act", int'(burst_act), int'(i < n));
            if (i < n)
                check(col_out == 9'(exp_col(sc, i, bl, il)), req, "col_out",
                      int'(col_out), exp_col(sc, i, bl, il));
            check(rd_valid == (!wr && i >= cl && i < n + cl), "R11", "rd_valid",
                  int'(rd_valid), int'(!wr && i >= cl && i < n + cl));
            cmd_term = (stop_after > 0 && i == n - 1);
            @(negedge clk);
        end
        cmd_term = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int blc, cl, bl, len, sc, stop;
        bit il, ws, wr;
        void'($urandom(32'd4711));
        rst = 1'b1; mode_ld = 0; mode_op = 0; cmd_start = 0;
        cmd_col = 0; cmd_wr = 0; cmd_term = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values and default settings
        check(!burst_act && !rd_valid && !mode_err, "R1", "reset outputs",
              int'({burst_act, rd_valid, mode_err}), 0);
        run_burst(9'h05A, 0, 1, 1, 0, 2, 0, "R1");

        // R2 legal load, R4 sequential BL8
        load_mode(mk_op(3, 0, 3, 0));
        check(mode_err == 1'b0, "R2", "mode_err after legal", int'(mode_err), 0);
        run_burst(9'h0AD, 0, 8, 8, 0, 3, 0, "R4");
        // R5 interleave BL8 and BL4
        load_mode(mk_op(3, 1, 2, 0));
        run_burst(9'h0AB, 0, 8, 8, 1, 2, 0, "R5");
        load_mode(mk_op(2, 1, 3, 0));
        run_burst(9'h117, 0, 4, 4, 1, 3, 0, "R5");
        // R7 sequential BL2 length
        load_mode(mk_op(1, 0, 2, 0));
        run_burst(9'h1FF, 0, 2, 2, 0, 2, 0, "R7");

        // R3 reserved latency code: error set, BL2 kept
        load_mode(mk_op(2, 0, 1, 0));
        check(mode_err == 1'b1, "R3", "mode_err reserved latency", int'(mode_err), 1);
        run_burst(9'h033, 0, 2, 2, 0, 2, 0, "R3");
        // R6 full page with interleave is reserved
        load_mode(mk_op(7, 1, 2, 0));
        check(mode_err == 1'b1, "R6", "mode_err page+interleave", int'(mode_err), 1);
        run_burst(9'h040, 1, 2, 2, 0, 2, 0, "R3");
        // R3 must-be-zero bit set
        load_mode(mk_op(2, 0, 2, 0) | 12'h400);
        check(mode_err == 1'b1, "R3", "mode_err stray bit", int'(mode_err), 1);
        load_mode(mk_op(2, 0, 2, 0));
        check(mode_err == 1'b0, "R2", "mode_err cleared", int'(mode_err), 0);

        // R6 full page wraps 511 -> 0, ends only on terminate (R8)
        load_mode(mk_op(7, 0, 2, 0));
        run_burst(500, 0, 0, 512, 0, 2, 20, "R6");
        // R8 terminate an 8-beat read after 3 beats
        load_mode(mk_op(3, 0, 3, 0));
        run_burst(9'h012, 0, 8, 8, 0, 3, 3, "R8");

        // R10 single-beat writes, reads unaffected
        load_mode(mk_op(3, 0, 2, 1));
        run_burst(9'h0C5, 1, 1, 1, 0, 2, 0, "R10");
        run_burst(9'h0C5, 0, 8, 8, 0, 2, 0, "R10");
        // R11 writes with full length give no rd_valid
        load_mode(mk_op(2, 0, 2, 0));
        run_burst(9'h0C5, 1, 4, 4, 0, 2, 0, "R11");

        // R9 restart during a burst
        cmd_col = 9'h010; cmd_wr = 0; cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        check(col_out == 9'h010, "R9", "first burst beat0", int'(col_out), 'h10);
        @(negedge clk);
        cmd_col = 9'h023; cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        for (int i = 0; i < 4; i++) begin
            check(burst_act && col_out == 9'(exp_col('h23, i, 4, 0)), "R9", "restart col",
                  int'(col_out), exp_col('h23, i, 4, 0));
            @(negedge clk);
        end
        check(!burst_act, "R9", "restart end", int'(burst_act), 0);
        repeat (4) @(negedge clk);

        // R12 start in load cycle and next cycle ignored
        mode_op = mk_op(1, 0, 2, 0); mode_ld = 1; cmd_col = 9'h008; cmd_start = 1;
        @(negedge clk);
        mode_ld = 0;
        check(!burst_act, "R12", "start in load cycle", int'(burst_act), 0);
        @(negedge clk);
        cmd_start = 0;
        check(!burst_act, "R12", "start one after load", int'(burst_act), 0);
        run_burst(9'h008, 0, 2, 2, 0, 2, 0, "R12");

        // Random legal modes and commands
        for (int k = 0; k < 40; k++) begin
            il  = $urandom_range(0, 1);
            blc = $urandom_range(0, 3);
            if (!il && $urandom_range(0, 7) == 0) blc = 7;
            cl  = $urandom_range(2, 3);
            ws  = $urandom_range(0, 1);
            wr  = $urandom_range(0, 1);
            sc  = $urandom_range(0, 511);
            bl  = (blc == 7) ? 512 : (1 << blc);
            load_mode(mk_op(blc, il, cl, ws));
            if (wr && ws) begin
                run_burst(sc, 1, 1, 1, 0, cl, 0, "R10");
            end else begin
                stop = (blc == 7) ? $urandom_range(4, 24) : 0;
                len  = bl;
                run_burst(sc, wr, len, bl, il, cl, stop, il ? "R5" : "R4");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule